// File: doc/BRIEF.md
# DMA Controller Register Front End

This block is the software-visible register layer of a multi-channel DMA controller. It takes 32-bit accesses into a 4 KB address window. Offsets below 0x80 hold a small global bank: an identification word, a reset-done status word, a system configuration word, a global control word and four capability words. Every offset from 0x80 upward belongs to a per-channel bank of 0x60 bytes. The block holds each channel's setup: control word, link field, element and frame counts, source and destination addresses, and the four address indexes. It drives that setup to the transfer engine over parallel ports.

Software starts or stops a channel by writing that channel's control word, and the block answers with a one-cycle enable or disable pulse. The engine feeds back its live source and destination addresses, element and frame counters and a busy flag, and these can be read through read-only registers. Writing the system configuration word with its reset bit set clears the whole configuration in one clock edge and sends a one-cycle reset pulse to the engine. Accesses narrower than 32 bits are refused.

Top module: `dmac_regfile`

## Requirements
- R1: An offset from 0x80 to 0xFFF selects channel (offset − 0x80) / 0x60, and the remainder selects the register inside that channel: 0x00 control, 0x04 link, 0x08 element count, 0x0C frame count, 0x10 source address, 0x14 destination address, 0x18 source element index, 0x1C destination element index, 0x20 source frame index, 0x24 destination frame index, 0x28 live source address, 0x2C live destination address, 0x30 live element counter, 0x34 live frame counter.
- R2: The control word keeps bits 25:0 except bit 7. Its 7-bit sync number takes bits 4:0 as its low part and control bits 20:19 as its bits 6:5. A read returns the stored word, with bit 7 showing the channel's live busy flag.
- R3: A control write with bit 7 set gives a one-cycle enable pulse for that channel only, in the cycle after the write. A control write with bit 7 clear gives a one-cycle disable pulse in the same way.
- R4: Offset 0x000 reads 0x40 and offset 0x004 reads 1. Offsets 0x010 to 0x01C read the four capability words. Writes to these offsets change nothing.
- R5: A write to the system configuration word (0x008) with bit 1 set clears every channel's configuration, returns the global control word to its reset value, and gives a one-cycle soft-reset pulse. In every case the stored value is the written value ANDed with 0x3321, and the word resets to 0.
- R6: The global control word (0x00C) keeps only the bits of mask 0x00FF00FF and resets to 0x00010010.
- R7: The element count keeps its low 24 bits and the frame count keeps its low 16 bits.
- R8: The element indexes are stored as the low 16 written bits sign-extended to 32. The frame indexes keep all 32 bits.
- R9: The live address registers return the low 16 bits of the engine's current addresses. The live counter registers return the engine's full counter values. All four are read-only.
- R10: The link register keeps an enable in bit 15 and a next-channel number in bits 4:0, and reads back 0 in every other bit.
- R11: Undefined offsets, and the banks of channels at or above the channel count, read zero. Writes to them change nothing.
- R12: An access with the full-word flag low changes nothing, gives no pulse and reads zero.
- R13: Read data appears in the cycle after the read request and is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_full_word | input | 1 | Access is 32 bits wide |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| live_src_addr | input | NCH*32 | Engine current source addresses |
| live_dst_addr | input | NCH*32 | Engine current destination addresses |
| live_elem | input | NCH*24 | Engine current element counters |
| live_frame | input | NCH*16 | Engine current frame counters |
| live_busy | input | NCH | Engine channel running flags |
| ch_en_pulse | output | NCH | Channel enable pulses |
| ch_dis_pulse | output | NCH | Channel disable pulses |
| soft_rst_pulse | output | 1 | Soft-reset pulse to the engine |
| cfg_ctrl | output | NCH*32 | Stored control words |
| cfg_sync | output | NCH*7 | Rebuilt sync numbers |
| cfg_link_en | output | NCH | Link enables |
| cfg_link_next | output | NCH*5 | Next channel numbers |
| cfg_ecnt | output | NCH*24 | Element counts |
| cfg_fcnt | output | NCH*16 | Frame counts |
| cfg_src | output | NCH*32 | Source start addresses |
| cfg_dst | output | NCH*32 | Destination start addresses |
| cfg_src_eidx | output | NCH*32 | Source element indexes |
| cfg_dst_eidx | output | NCH*32 | Destination element indexes |
| cfg_src_fidx | output | NCH*32 | Source frame indexes |
| cfg_dst_fidx | output | NCH*32 | Destination frame indexes |
| cfg_gctl | output | 32 | Global control word |
| cfg_sysconf | output | 32 | System configuration word |

## Verification
Two pairs of events can share a cycle. First, the engine can change a live value in the same cycle that software reads it. The bench changes a channel's live address and busy flag at the instant it raises the read request, and expects the new value back, because the read is captured at that edge. Second, a soft reset can arrive right behind a channel start. The bench writes a control word with the enable bit set and follows it at once with a reset write. It expects the enable pulse in the first cycle and the soft-reset pulse in the second, and then expects every configuration register back at its reset value.

// File: rtl/dmac_reg_pkg.sv
package dmac_reg_pkg;
   localparam int DW        = 32;
   localparam int AW        = 12;
   localparam int CH_BASE   = 'h080;
   localparam int CH_STRIDE = 'h060;
   localparam int ECNT_W    = 24;
   localparam int FCNT_W    = 16;
   localparam int SYNC_W    = 7;
   localparam int LNK_W     = 5;
   localparam int LOC_W     = 7;

   localparam logic [AW-1:0] G_IDENT  = 12'h000;
   localparam logic [AW-1:0] G_STAT   = 12'h004;
   localparam logic [AW-1:0] G_SYSCFG = 12'h008;
   localparam logic [AW-1:0] G_GCTL   = 12'h00C;
   localparam logic [AW-1:0] G_CAP0   = 12'h010;
   localparam int            N_CAPS   = 4;

   localparam logic [LOC_W-1:0] R_CTRL  = 7'h00;
   localparam logic [LOC_W-1:0] R_LINK  = 7'h04;
   localparam logic [LOC_W-1:0] R_ECNT  = 7'h08;
   localparam logic [LOC_W-1:0] R_FCNT  = 7'h0C;
   localparam logic [LOC_W-1:0] R_SRC   = 7'h10;
   localparam logic [LOC_W-1:0] R_DST   = 7'h14;
   localparam logic [LOC_W-1:0] R_SEIDX = 7'h18;
   localparam logic [LOC_W-1:0] R_DEIDX = 7'h1C;
   localparam logic [LOC_W-1:0] R_SFIDX = 7'h20;
   localparam logic [LOC_W-1:0] R_DFIDX = 7'h24;
   localparam logic [LOC_W-1:0] R_LSRC  = 7'h28;
   localparam logic [LOC_W-1:0] R_LDST  = 7'h2C;
   localparam logic [LOC_W-1:0] R_LELEM = 7'h30;
   localparam logic [LOC_W-1:0] R_LFRM  = 7'h34;

   localparam logic [DW-1:0] CTRL_KEEP   = 32'h03FF_FF7F;
   localparam logic [DW-1:0] SYSCFG_KEEP = 32'h0000_3321;
   localparam logic [DW-1:0] GCTL_KEEP   = 32'h00FF_00FF;
   localparam logic [DW-1:0] GCTL_RST    = 32'h0001_0010;
   localparam logic [DW-1:0] IDENT_VAL   = 32'h0000_0040;
   localparam logic [DW-1:0] STAT_VAL    = 32'h0000_0001;
   localparam int            RUN_BIT     = 7;
   localparam int            SRST_BIT    = 1;
   localparam int            LINK_EN_BIT = 15;

   typedef struct packed {
      logic [DW-1:0]     ctrl;
      logic              link_en;
      logic [LNK_W-1:0]  link_next;
      logic [ECNT_W-1:0] ecnt;
      logic [FCNT_W-1:0] fcnt;
      logic [DW-1:0]     src;
      logic [DW-1:0]     dst;
      logic [DW-1:0]     seidx;
      logic [DW-1:0]     deidx;
      logic [DW-1:0]     sfidx;
      logic [DW-1:0]     dfidx;
   } dmac_chan_cfg_t;
endpackage

// File: rtl/dmac_addr_decode.sv
module dmac_addr_decode
   import dmac_reg_pkg::*;
#(
   parameter  int NCH = 8,
   localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic [AW-1:0]    addr,
   output logic             hit,
   output logic [CIW-1:0]   idx,
   output logic [LOC_W-1:0] loc
);
   localparam int MAX_CH = ((1 << AW) - CH_BASE) / CH_STRIDE;

   if (NCH < 1 || NCH > MAX_CH || NCH > (1 << LNK_W))
      $error("dmac_addr_decode: NCH out of range");

   always_comb begin
      hit = 1'b0;
      idx = '0;
      loc = '0;
      for (int c = 0; c < NCH; c++) begin
         if (int'(addr) >= CH_BASE + c * CH_STRIDE &&
             int'(addr) <  CH_BASE + (c + 1) * CH_STRIDE) begin
            hit = 1'b1;
            idx = CIW'(c);
            loc = LOC_W'(int'(addr) - CH_BASE - c * CH_STRIDE);
         end
      end
   end
endmodule

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank
   import dmac_reg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_clr,
   input  logic              wr_en,
   input  logic [LOC_W-1:0]  loc,
   input  logic [DW-1:0]     wdata,
   input  logic [DW-1:0]     live_src,
   input  logic [DW-1:0]     live_dst,
   input  logic [ECNT_W-1:0] live_elem,
   input  logic [FCNT_W-1:0] live_frame,
   input  logic              live_busy,
   output dmac_chan_cfg_t    cfg,
   output logic [SYNC_W-1:0] sync_id,
   output logic [DW-1:0]     rd_data,
   output logic              en_pulse,
   output logic              dis_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg       <= '0;
         en_pulse  <= 1'b0;
         dis_pulse <= 1'b0;
      end else begin
         en_pulse  <= 1'b0;
         dis_pulse <= 1'b0;
         if (soft_clr) begin
            cfg <= '0;
         end else if (wr_en) begin
            case (loc)
               R_CTRL: begin
                  cfg.ctrl  <= wdata & CTRL_KEEP;
                  en_pulse  <= wdata[RUN_BIT];
                  dis_pulse <= !wdata[RUN_BIT];
               end
               R_LINK: begin
                  cfg.link_en   <= wdata[LINK_EN_BIT];
                  cfg.link_next <= wdata[LNK_W-1:0];
               end
               R_ECNT:  cfg.ecnt  <= wdata[ECNT_W-1:0];
               R_FCNT:  cfg.fcnt  <= wdata[FCNT_W-1:0];
               R_SRC:   cfg.src   <= wdata;
               R_DST:   cfg.dst   <= wdata;
               R_SEIDX: cfg.seidx <= {{16{wdata[15]}}, wdata[15:0]};
               R_DEIDX: cfg.deidx <= {{16{wdata[15]}}, wdata[15:0]};
               R_SFIDX: cfg.sfidx <= wdata;
               R_DFIDX: cfg.dfidx <= wdata;
               default: ;
            endcase
         end
      end
   end

   assign sync_id = {cfg.ctrl[20:19], cfg.ctrl[4:0]};

   always_comb begin
      case (loc)
         R_CTRL:  rd_data = cfg.ctrl | (DW'(live_busy) << RUN_BIT);
         R_LINK:  rd_data = (DW'(cfg.link_en) << LINK_EN_BIT) | DW'(cfg.link_next);
         R_ECNT:  rd_data = DW'(cfg.ecnt);
         R_FCNT:  rd_data = DW'(cfg.fcnt);
         R_SRC:   rd_data = cfg.src;
         R_DST:   rd_data = cfg.dst;
         R_SEIDX: rd_data = cfg.seidx;
         R_DEIDX: rd_data = cfg.deidx;
         R_SFIDX: rd_data = cfg.sfidx;
         R_DFIDX: rd_data = cfg.dfidx;
         R_LSRC:  rd_data = {16'h0, live_src[15:0]};
         R_LDST:  rd_data = {16'h0, live_dst[15:0]};
         R_LELEM: rd_data = DW'(live_elem);
         R_LFRM:  rd_data = DW'(live_frame);
         default: rd_data = '0;
      endcase
   end

   assert_pulse_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_pulse || dis_pulse) |-> $past(wr_en && !soft_clr && loc == R_CTRL));

   assert_softclr_wipes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(soft_clr) |-> (cfg.ecnt == '0 && cfg.ctrl == '0 && !cfg.link_en));
endmodule

// File: rtl/dmac_glob_regs.sv
module dmac_glob_regs
   import dmac_reg_pkg::*;
#(
   parameter logic [N_CAPS*DW-1:0] CAPS = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          soft_clr,
   output logic          soft_rst_pulse,
   output logic [DW-1:0] gctl,
   output logic [DW-1:0] sysconf,
   output logic [DW-1:0] rd_data
);
   assign soft_clr = wr_en && addr == G_SYSCFG && wdata[SRST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gctl           <= GCTL_RST;
         sysconf        <= '0;
         soft_rst_pulse <= 1'b0;
      end else begin
         soft_rst_pulse <= soft_clr;
         if (soft_clr)
            gctl <= GCTL_RST;
         else if (wr_en && addr == G_GCTL)
            gctl <= wdata & GCTL_KEEP;
         if (wr_en && addr == G_SYSCFG)
            sysconf <= wdata & SYSCFG_KEEP;
      end
   end

   logic [DW-1:0] cap_word [N_CAPS];
   for (genvar k = 0; k < N_CAPS; k++) begin : g_cap
      assign cap_word[k] = CAPS[k*DW +: DW];
   end

   always_comb begin
      rd_data = '0;
      if (addr == G_IDENT)       rd_data = IDENT_VAL;
      else if (addr == G_STAT)   rd_data = STAT_VAL;
      else if (addr == G_SYSCFG) rd_data = sysconf;
      else if (addr == G_GCTL)   rd_data = gctl;
      else begin
         for (int k = 0; k < N_CAPS; k++)
            if (addr == G_CAP0 + AW'(4 * k)) rd_data = cap_word[k];
      end
   end

   assert_gctl_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gctl & ~GCTL_KEEP) == '0);

   assert_srst_restores_R5: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_pulse |-> gctl == GCTL_RST);
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
   import dmac_reg_pkg::*;
#(
   parameter int NCH = 8,
   parameter logic [N_CAPS*DW-1:0] CAPS = {32'h0000_00FF, 32'h0000_01FF,
                                           32'h0000_0002, 32'h000C_0000}
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_sel,
   input  logic                  bus_wr,
   input  logic                  bus_full_word,
   input  logic [AW-1:0]         bus_addr,
   input  logic [DW-1:0]         bus_wdata,
   output logic [DW-1:0]         bus_rdata,
   input  logic [NCH*DW-1:0]     live_src_addr,
   input  logic [NCH*DW-1:0]     live_dst_addr,
   input  logic [NCH*ECNT_W-1:0] live_elem,
   input  logic [NCH*FCNT_W-1:0] live_frame,
   input  logic [NCH-1:0]        live_busy,
   output logic [NCH-1:0]        ch_en_pulse,
   output logic [NCH-1:0]        ch_dis_pulse,
   output logic                  soft_rst_pulse,
   output logic [NCH*DW-1:0]     cfg_ctrl,
   output logic [NCH*SYNC_W-1:0] cfg_sync,
   output logic [NCH-1:0]        cfg_link_en,
   output logic [NCH*LNK_W-1:0]  cfg_link_next,
   output logic [NCH*ECNT_W-1:0] cfg_ecnt,
   output logic [NCH*FCNT_W-1:0] cfg_fcnt,
   output logic [NCH*DW-1:0]     cfg_src,
   output logic [NCH*DW-1:0]     cfg_dst,
   output logic [NCH*DW-1:0]     cfg_src_eidx,
   output logic [NCH*DW-1:0]     cfg_dst_eidx,
   output logic [NCH*DW-1:0]     cfg_src_fidx,
   output logic [NCH*DW-1:0]     cfg_dst_fidx,
   output logic [DW-1:0]         cfg_gctl,
   output logic [DW-1:0]         cfg_sysconf
);
   localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;

   logic wr_ok, rd_ok, in_glob;
   assign wr_ok   = bus_sel && bus_wr && bus_full_word;
   assign rd_ok   = bus_sel && !bus_wr && bus_full_word;
   assign in_glob = int'(bus_addr) < CH_BASE;

   logic             ch_hit;
   logic [CIW-1:0]   ch_idx;
   logic [LOC_W-1:0] ch_loc;

   dmac_addr_decode #(.NCH(NCH)) dec_i (
      .addr(bus_addr), .hit(ch_hit), .idx(ch_idx), .loc(ch_loc)
   );

   logic          soft_clr;
   logic [DW-1:0] glob_rd;

   dmac_glob_regs #(.CAPS(CAPS)) glob_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ok && in_glob),
      .addr(bus_addr), .wdata(bus_wdata), .soft_clr(soft_clr),
      .soft_rst_pulse(soft_rst_pulse), .gctl(cfg_gctl),
      .sysconf(cfg_sysconf), .rd_data(glob_rd)
   );

   logic [DW-1:0] chan_rd [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dmac_chan_cfg_t    cfg_c;
      logic [SYNC_W-1:0] sync_c;

      dmac_chan_bank bank_i (
         .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
         .wr_en(wr_ok && ch_hit && ch_idx == CIW'(c)),
         .loc(ch_loc), .wdata(bus_wdata),
         .live_src(live_src_addr[c*DW +: DW]),
         .live_dst(live_dst_addr[c*DW +: DW]),
         .live_elem(live_elem[c*ECNT_W +: ECNT_W]),
         .live_frame(live_frame[c*FCNT_W +: FCNT_W]),
         .live_busy(live_busy[c]),
         .cfg(cfg_c), .sync_id(sync_c), .rd_data(chan_rd[c]),
         .en_pulse(ch_en_pulse[c]), .dis_pulse(ch_dis_pulse[c])
      );

      assign cfg_ctrl[c*DW +: DW]             = cfg_c.ctrl;
      assign cfg_sync[c*SYNC_W +: SYNC_W]     = sync_c;
      assign cfg_link_en[c]                   = cfg_c.link_en;
      assign cfg_link_next[c*LNK_W +: LNK_W]  = cfg_c.link_next;
      assign cfg_ecnt[c*ECNT_W +: ECNT_W]     = cfg_c.ecnt;
      assign cfg_fcnt[c*FCNT_W +: FCNT_W]     = cfg_c.fcnt;
      assign cfg_src[c*DW +: DW]              = cfg_c.src;
      assign cfg_dst[c*DW +: DW]              = cfg_c.dst;
      assign cfg_src_eidx[c*DW +: DW]         = cfg_c.seidx;
      assign cfg_dst_eidx[c*DW +: DW]         = cfg_c.deidx;
      assign cfg_src_fidx[c*DW +: DW]         = cfg_c.sfidx;
      assign cfg_dst_fidx[c*DW +: DW]         = cfg_c.dfidx;
   end

   logic [DW-1:0] rd_mux;
   always_comb begin
      if (in_glob)     rd_mux = glob_rd;
      else if (ch_hit) rd_mux = chan_rd[ch_idx];
      else             rd_mux = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata <= '0;
      else if (rd_ok) bus_rdata <= rd_mux;
      else            bus_rdata <= '0;
   end

   assert_rdata_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_ok) |-> bus_rdata == '0);

   assert_one_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_en_pulse | ch_dis_pulse));

   assert_narrow_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_full_word) |=> (ch_en_pulse == '0 && ch_dis_pulse == '0 && !soft_rst_pulse));
endmodule

// File: tb/dmac_regfile_tb.sv
module dmac_regfile_tb_top;
   localparam int NCH = 8;
   localparam logic [127:0] CAPS_EXP = {32'h0000_00FF, 32'h0000_01FF,
                                        32'h0000_0002, 32'h000C_0000};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          bus_sel = 0, bus_wr = 0, bus_full_word = 0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NCH*32-1:0] live_src_addr = '0, live_dst_addr = '0;
   logic [NCH*24-1:0] live_elem = '0;
   logic [NCH*16-1:0] live_frame = '0;
   logic [NCH-1:0]    live_busy = '0;
   logic [NCH-1:0]    ch_en_pulse, ch_dis_pulse;
   logic              soft_rst_pulse;
   logic [NCH*32-1:0] cfg_ctrl, cfg_src, cfg_dst, cfg_src_eidx, cfg_dst_eidx,
                      cfg_src_fidx, cfg_dst_fidx;
   logic [NCH*7-1:0]  cfg_sync;
   logic [NCH-1:0]    cfg_link_en;
   logic [NCH*5-1:0]  cfg_link_next;
   logic [NCH*24-1:0] cfg_ecnt;
   logic [NCH*16-1:0] cfg_fcnt;
   logic [31:0]       cfg_gctl, cfg_sysconf;

   dmac_regfile #(.NCH(NCH)) dut_i (.*);

   int checks = 0, failures = 0;

   logic [31:0] m_ctrl [NCH], m_link [NCH], m_ecnt [NCH], m_fcnt [NCH],
                m_src [NCH], m_dst [NCH], m_sei [NCH], m_dei [NCH],
                m_sfi [NCH], m_dfi [NCH];
   logic [31:0] m_gctl, m_cfg;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic mdl_clear();
      for (int c = 0; c < NCH; c++) begin
         m_ctrl[c] = 0; m_link[c] = 0; m_ecnt[c] = 0; m_fcnt[c] = 0;
         m_src[c] = 0; m_dst[c] = 0; m_sei[c] = 0; m_dei[c] = 0;
         m_sfi[c] = 0; m_dfi[c] = 0;
      end
      m_gctl = 32'h0001_0010;
   endtask

   function automatic logic [31:0] sx16(input logic [31:0] v);
      return {{16{v[15]}}, v[15:0]};
   endfunction

   // Expected read value from requirements R1, R2, R4..R11
   function automatic logic [31:0] exp_rd(input int a);
      int c, r;
      if (a < 'h80) begin
         case (a)
            'h00: return 32'h40;
            'h04: return 32'h1;
            'h08: return m_cfg;
            'h0C: return m_gctl;
            'h10, 'h14, 'h18, 'h1C: return CAPS_EXP[((a - 'h10) / 4) * 32 +: 32];
            default: return 0;
         endcase
      end
      c = (a - 'h80) / 'h60;
      r = (a - 'h80) % 'h60;
      if (c >= NCH) return 0;
      case (r)
         'h00: return m_ctrl[c] | (32'(live_busy[c]) << 7);
         'h04: return m_link[c];
         'h08: return m_ecnt[c];
         'h0C: return m_fcnt[c];
         'h10: return m_src[c];
         'h14: return m_dst[c];
         'h18: return m_sei[c];
         'h1C: return m_dei[c];
         'h20: return m_sfi[c];
         'h24: return m_dfi[c];
         'h28: return {16'h0, live_src_addr[c*32 +: 16]};
         'h2C: return {16'h0, live_dst_addr[c*32 +: 16]};
         'h30: return 32'(live_elem[c*24 +: 24]);
         'h34: return 32'(live_frame[c*16 +: 16]);
         default: return 0;
      endcase
   endfunction

   task automatic mdl_write(input int a, input logic [31:0] d);
      int c, r;
      if (a < 'h80) begin
         if (a == 'h08) begin
            if (d[1]) mdl_clear();
            m_cfg = d & 32'h3321;
         end else if (a == 'h0C) m_gctl = d & 32'h00FF_00FF;
         return;
      end
      c = (a - 'h80) / 'h60;
      r = (a - 'h80) % 'h60;
      if (c >= NCH) return;
      case (r)
         'h00: m_ctrl[c] = d & 32'h03FF_FF7F;
         'h04: m_link[c] = d & 32'h0000_801F;
         'h08: m_ecnt[c] = d & 32'h00FF_FFFF;
         'h0C: m_fcnt[c] = d & 32'h0000_FFFF;
         'h10: m_src[c] = d;
         'h14: m_dst[c] = d;
         'h18: m_sei[c] = sx16(d);
         'h1C: m_dei[c] = sx16(d);
         'h20: m_sfi[c] = d;
         'h24: m_dfi[c] = d;
         default: ;
      endcase
   endtask

   // Tasks start and end at a falling edge
   task automatic bus_write(input int a, input logic [31:0] d, input logic full);
      bus_sel = 1; bus_wr = 1; bus_full_word = full;
      bus_addr = 12'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; bus_full_word = 0;
   endtask

   task automatic bus_read(input int a, input logic full, output logic [31:0] d);
      bus_sel = 1; bus_wr = 0; bus_full_word = full; bus_addr = 12'(a);
      @(negedge clk);
      bus_sel = 0; bus_full_word = 0;
      d = bus_rdata;
   endtask

   // Full write with model update and pulse checks (R3, R5)
   task automatic wr_chk(input int a, input logic [31:0] d);
      logic [NCH-1:0] een, edis;
      int c, r;
      een = '0; edis = '0;
      if (a >= 'h80) begin
         c = (a - 'h80) / 'h60;
         r = (a - 'h80) % 'h60;
         if (c < NCH && r == 0) begin
            een[c] = d[7];
            edis[c] = !d[7];
         end
      end
      bus_write(a, d, 1'b1);
      mdl_write(a, d);
      chk("R3 enable pulse", 32'(ch_en_pulse), 32'(een));
      chk("R3 disable pulse", 32'(ch_dis_pulse), 32'(edis));
      chk("R5 soft reset pulse", 32'(soft_rst_pulse), 32'(a == 'h08 && d[1]));
   endtask

   task automatic rd_chk(input string req, input int a);
      logic [31:0] v;
      bus_read(a, 1'b1, v);
      chk(req, v, exp_rd(a));
   endtask

   function automatic int ch_addr(input int c, input int r);
      return 'h80 + c * 'h60 + r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      mdl_clear();
      m_cfg = 0;
      for (int c = 0; c < NCH; c++) begin
         live_src_addr[c*32 +: 32] = $urandom;
         live_dst_addr[c*32 +: 32] = $urandom;
         live_elem[c*24 +: 24] = 24'($urandom);
         live_frame[c*16 +: 16] = 16'($urandom);
      end
      live_busy = 8'hA5;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // Reset state
      chk("R13 idle rdata", bus_rdata, 32'h0);
      rd_chk("R4 ident", 'h00);
      rd_chk("R4 status", 'h04);
      rd_chk("R6 gctl reset", 'h0C);
      rd_chk("R5 sysconf reset", 'h08);
      rd_chk("R4 cap word", 'h18);
      rd_chk("R2 ctrl reset readback", ch_addr(0, 0));

      // R4 read-only global words
      wr_chk('h00, 32'hFFFF_FFFF);
      wr_chk('h04, 32'h0);
      wr_chk('h1C, 32'h1234_5678);
      rd_chk("R4 ident after write", 'h00);
      rd_chk("R4 status after write", 'h04);
      rd_chk("R4 cap after write", 'h1C);

      // R6 mask
      wr_chk('h0C, 32'hFFFF_FFFF);
      chk("R6 gctl port", cfg_gctl, 32'h00FF_00FF);

      // R2 sync rebuild with enable
      wr_chk(ch_addr(3, 0), 32'h0018_0085);
      chk("R2 sync number", 32'(cfg_sync[3*7 +: 7]), 32'h65);
      chk("R2 ctrl port", cfg_ctrl[3*32 +: 32], 32'h0018_0005);
      rd_chk("R2 ctrl readback", ch_addr(3, 0));
      @(negedge clk);
      chk("R3 pulse one cycle", 32'(ch_en_pulse), 32'h0);
      wr_chk(ch_addr(7, 0), 32'h0000_0001);

      // R7, R8, R10
      wr_chk(ch_addr(2, 'h08), 32'hABCD_EF12);
      chk("R7 element count port", 32'(cfg_ecnt[2*24 +: 24]), 32'h00CD_EF12);
      wr_chk(ch_addr(2, 'h0C), 32'h9876_5432);
      rd_chk("R7 frame count", ch_addr(2, 'h0C));
      wr_chk(ch_addr(2, 'h18), 32'h0000_8001);
      rd_chk("R8 element index sign", ch_addr(2, 'h18));
      wr_chk(ch_addr(2, 'h1C), 32'hFFFF_7FFF);
      chk("R8 element index positive", cfg_dst_eidx[2*32 +: 32], 32'h0000_7FFF);
      wr_chk(ch_addr(2, 'h20), 32'h8000_0003);
      rd_chk("R8 frame index full", ch_addr(2, 'h20));
      wr_chk(ch_addr(2, 'h04), 32'hFFFF_FFFF);
      chk("R10 link next port", 32'(cfg_link_next[2*5 +: 5]), 32'h1F);
      rd_chk("R10 link readback", ch_addr(2, 'h04));

      // R9 live registers read-only, same-cycle update
      wr_chk(ch_addr(4, 'h28), 32'h1111_1111);
      rd_chk("R9 live src readonly", ch_addr(4, 'h28));
      live_dst_addr[5*32 +: 32] = 32'hDEAD_BEEF;
      live_busy[5] = 1'b0;
      rd_chk("R9 live dst same cycle", ch_addr(5, 'h2C));
      live_busy[5] = 1'b1;
      rd_chk("R2 busy same cycle", ch_addr(5, 0));
      rd_chk("R9 live element counter", ch_addr(6, 'h30));
      rd_chk("R9 live frame counter", ch_addr(1, 'h34));

      // R1 / R11 boundaries
      wr_chk(ch_addr(7, 'h5C), 32'h1234_5678);
      rd_chk("R1 last channel last reg", ch_addr(7, 'h34));
      wr_chk(ch_addr(NCH, 0), 32'h0000_0080);
      rd_chk("R11 channel beyond count", ch_addr(NCH, 0));
      rd_chk("R11 undefined global", 'h40);
      rd_chk("R11 undefined channel offset", ch_addr(0, 'h5C));
      rd_chk("R11 top of window", 'hFFC);

      // R12 narrow access
      bus_write(ch_addr(1, 'h10), 32'hCAFE_0000, 1'b0);
      chk("R12 no pulse", 32'(ch_en_pulse | ch_dis_pulse), 32'h0);
      rd_chk("R12 write ignored", ch_addr(1, 'h10));
      bus_read('h00, 1'b0, v);
      chk("R12 narrow read zero", v, 32'h0);
      bus_write(ch_addr(1, 0), 32'h80, 1'b0);
      chk("R12 narrow ctrl no pulse", 32'(ch_en_pulse), 32'h0);

      // R5 soft reset right behind a start
      wr_chk(ch_addr(6, 'h10), 32'h5555_AAAA);
      wr_chk(ch_addr(6, 0), 32'h0000_0080);
      wr_chk('h08, 32'hFFFF_FFFF);
      chk("R5 sysconf stored", cfg_sysconf, 32'h0000_3321);
      chk("R5 gctl restored", cfg_gctl, 32'h0001_0010);
      rd_chk("R5 channel cleared", ch_addr(6, 'h10));
      rd_chk("R5 sync cleared", ch_addr(3, 0));
      @(negedge clk);
      chk("R5 pulse one cycle", 32'(soft_rst_pulse), 32'h0);
      wr_chk('h08, 32'h0000_3000);
      rd_chk("R5 plain sysconf write", 'h08);

      // Random mix
      for (int i = 0; i < 600; i++) begin
         int sel, a;
         logic [31:0] d;
         sel = int'($urandom % 8);
         if (sel < 5) a = ch_addr(int'($urandom % (NCH + 1)), int'($urandom % 26) * 4);
         else if (sel < 7) a = int'($urandom % 'h20) & ~3;
         else a = int'($urandom % 'h1000) & ~3;
         a = a & 'hFFC;
         d = $urandom;
         if (a == 'h08 && ($urandom % 4) != 0) d[1] = 1'b0;
         if ($urandom % 2) wr_chk(a, d);
         if ((i % 50) == 0) begin
            live_busy = 8'($urandom);
            live_elem[0 +: 24] = 24'($urandom);
         end
         rd_chk("R1 random readback", a);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule